// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer operand into a floating-point value in the 64-bit binary double layout. A two-bit command picks how the operand is read (two's-complement signed or plain unsigned) and the precision to round to (53 significant bits or 24 significant bits). When 24-bit precision is chosen, the result is still packed in the double layout. Its fraction field then has zeros below the 23 kept fraction bits.

The whole path is built once and serves all four conversions. It takes the sign, recovers the magnitude, normalises by a leading-zero count, rounds to nearest with ties to even, adds the exponent bias and packs the word. An operand is taken over a valid/ready handshake. The result is then held on a valid/ready output until it is consumed. An inexact flag travels with every result. The block holds one conversion at a time.

Top module: `i2f_conv`

## Requirements
- R1: `in_ready` is 1 only while no conversion is held. An operand is taken on a rising edge with `in_valid` and `in_ready` both 1. `in_valid` has no effect while a conversion is held. A result shown with `out_valid` stays unchanged until a rising edge with `out_ready` 1 takes it, and `in_ready` returns to 1 at that edge.
- R2: An operand of zero gives a result of 64 zero bits, with `inexact` 0, for every command.
- R3: Command bit 1 selects the reading of the operand: 0 means signed, 1 means unsigned. For signed, the result sign (bit 63) equals operand bit 63. For unsigned, the sign is 0.
- R4: A negative signed operand is converted from its magnitude, the bitwise inverse of the operand plus one.
- R5: With command bit 0 equal to 0, the magnitude is rounded to 53 significant bits, to nearest with ties to the even value.
- R6: With command bit 0 equal to 1, the magnitude is rounded to 24 significant bits, to nearest with ties to even, and result bits 28 to 0 are 0.
- R7: The result is packed as the sign in bit 63, the exponent plus 1023 in bits 62 to 52, and the fraction below the leading one in bits 51 to 0. The exponent is the bit position of the magnitude's leading one.
- R8: When rounding carries out of the significand, the exponent rises by one and the fraction field is 0.
- R9: The signed operand 0x8000000000000000 converts exactly, to 0xC3E0000000000000, with `inexact` 0.
- R10: `inexact` is 1 exactly when any magnitude bit below the kept significand is 1.
- R11: `out_valid` becomes 1 at the second rising edge after the edge that takes the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand |
| in_op | input | 64 | Integer operand |
| in_cmd | input | 2 | Bit 1: 1 = unsigned; bit 0: 1 = 24-bit precision |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 64 | Packed double-layout result |
| out_inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
The assertions assume that `out_ready` may be held low for any number of cycles. They also assume that `in_valid` may stay high while a conversion is in flight. Both are allowed and must change nothing. No limit is placed on the operand or command values. The stimulus therefore mixes stalls of zero to several cycles with operands held on the input during busy cycles. It covers every command against full-width, narrow and tie-producing operands, so every assumed freedom is exercised rather than avoided.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int DW       = 64;
  localparam int EW       = 11;
  localparam int FW       = 52;
  localparam int BIAS     = 1023;
  localparam int DBL_KEEP = 53;
  localparam int SGL_KEEP = 24;
  localparam int LZW      = $clog2(DW);

  typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_RND, ST_DONE} i2f_state_t;

  // position count of zeros above the leading one (operand must be nonzero)
  function automatic logic [LZW-1:0] lead_zeros(input logic [DW-1:0] v);
    logic [LZW-1:0] n;
    n = '0;
    for (int i = 0; i < DW; i++) begin
      if (v[i]) n = LZW'(DW - 1 - i);
    end
    return n;
  endfunction

  // round to nearest, ties to even
  function automatic logic rne_up(input logic lsb, input logic g,
                                  input logic r, input logic x);
    return g & (lsb | r | x);
  endfunction
endpackage

// File: rtl/i2f_prep.sv
module i2f_prep
  import i2f_pkg::*;
#(
  parameter int OPW = DW
) (
  input  logic [OPW-1:0] op,
  input  logic           is_unsigned,
  output logic           sign,
  output logic [OPW-1:0] mag,
  output logic           zero
);
  assign sign = ~is_unsigned & op[OPW-1];
  assign mag  = sign ? (~op + OPW'(1)) : op;
  assign zero = (op == '0);
endmodule

// File: rtl/i2f_norm.sv
module i2f_norm
  import i2f_pkg::*;
#(
  parameter int OPW = DW
) (
  input  logic [OPW-1:0] mag,
  output logic [OPW-1:0] frac,
  output logic [LZW-1:0] exp_unb
);
  logic [LZW-1:0] lz;
  assign lz      = lead_zeros(mag);
  assign frac    = mag << lz;
  assign exp_unb = LZW'(OPW - 1) - lz;
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int KEEP = DBL_KEEP,
  parameter int OPW  = DW
) (
  input  logic [OPW-1:0] frac,
  input  logic [LZW-1:0] exp_unb,
  input  logic           sign,
  input  logic           zero,
  output logic [OPW-1:0] word,
  output logic           inexact
);
  localparam int DROP = OPW - KEEP;

  logic            lsb_b, grd_b, rnd_b, stk_b, inc;
  logic [KEEP:0]   sum;
  logic            carry;
  logic [FW-1:0]   fld;
  logic [EW-1:0]   bexp;

  assign lsb_b = frac[DROP];
  assign grd_b = frac[DROP-1];
  assign rnd_b = frac[DROP-2];
  assign stk_b = |frac[DROP-3:0];
  assign inc   = rne_up(lsb_b, grd_b, rnd_b, stk_b);
  assign sum   = {1'b0, frac[OPW-1:DROP]} + (KEEP+1)'(inc);
  assign carry = sum[KEEP];
  assign fld   = carry ? '0 : {sum[KEEP-2:0], {(FW-KEEP+1){1'b0}}};
  assign bexp  = EW'(BIAS) + EW'(exp_unb) + EW'(carry);

  assign word    = zero ? '0 : {sign, bexp, fld};
  assign inexact = ~zero & (grd_b | rnd_b | stk_b);
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
  import i2f_pkg::*;
#(
  parameter int OPW = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic [1:0]     in_cmd,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OPW-1:0] out_res,
  output logic           out_inexact
);
  localparam int NPREC = 2;

  i2f_state_t st;

  logic           accept_evt;
  logic           pre_sign, pre_zero;
  logic [OPW-1:0] pre_mag;
  logic           op_sign, op_zero, res_single, res_unsigned;
  logic [OPW-1:0] op_mag;
  logic [OPW-1:0] nrm_frac_w, nrm_frac;
  logic [LZW-1:0] nrm_exp_w, nrm_exp;
  logic [OPW-1:0] rnd_word [NPREC];
  logic [NPREC-1:0] rnd_inex;

  assign in_ready   = (st == ST_IDLE);
  assign out_valid  = (st == ST_DONE);
  assign accept_evt = in_valid & in_ready;

  i2f_prep #(.OPW(OPW)) u_prep (
    .op(in_op), .is_unsigned(in_cmd[1]),
    .sign(pre_sign), .mag(pre_mag), .zero(pre_zero)
  );

  i2f_norm #(.OPW(OPW)) u_norm (
    .mag(op_mag), .frac(nrm_frac_w), .exp_unb(nrm_exp_w)
  );

  for (genvar gi = 0; gi < NPREC; gi++) begin : g_prec
    localparam int KP = (gi == 0) ? DBL_KEEP : SGL_KEEP;
    i2f_round #(.KEEP(KP), .OPW(OPW)) u_rnd (
      .frac(nrm_frac), .exp_unb(nrm_exp), .sign(op_sign), .zero(op_zero),
      .word(rnd_word[gi]), .inexact(rnd_inex[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      op_sign      <= 1'b0;
      op_zero      <= 1'b0;
      op_mag       <= '0;
      res_single   <= 1'b0;
      res_unsigned <= 1'b0;
      nrm_frac     <= '0;
      nrm_exp      <= '0;
      out_res      <= '0;
      out_inexact  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept_evt) begin
          op_sign      <= pre_sign;
          op_zero      <= pre_zero;
          op_mag       <= pre_mag;
          res_single   <= in_cmd[0];
          res_unsigned <= in_cmd[1];
          st           <= ST_NORM;
        end
        ST_NORM: begin
          nrm_frac <= nrm_frac_w;
          nrm_exp  <= nrm_exp_w;
          st       <= ST_RND;
        end
        ST_RND: begin
          out_res     <= rnd_word[res_single ? 1 : 0];
          out_inexact <= rnd_inex[res_single ? 1 : 0];
          st          <= ST_DONE;
        end
        ST_DONE: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2f_chk.sv
module i2f_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_res,
  input logic        out_inexact,
  input logic        accept_evt,
  input logic        res_single,
  input logic        res_unsigned
);
  // R1
  held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_inexact));

  // R1
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept_evt, 3) |-> $rose(out_valid));

  // R2
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_res[62:52] == 11'd0 |-> out_res == 64'd0 && !out_inexact);

  // R3
  unsigned_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_unsigned |-> !out_res[63]);

  // R6
  single_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res_single |-> out_res[28:0] == 29'd0);

  // R7
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_res != 64'd0 |-> out_res[62:52] >= 11'd1023 && out_res[62:52] <= 11'd1087);
endmodule

bind i2f_conv i2f_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_res(out_res), .out_inexact(out_inexact),
  .accept_evt(accept_evt), .res_single(res_single), .res_unsigned(res_unsigned)
);

// File: tb/tb_i2f_conv.sv
module tb_i2f_conv;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_op = '0;
  logic [1:0]  in_cmd = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_res;
  logic        out_inexact;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2f_conv dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: integer remainder comparison at the chosen precision.
  function automatic logic [64:0] ref_conv(input logic [63:0] op, input logic [1:0] cmd);
    logic        sg, ix;
    logic [63:0] m, keep, rem, half, fr;
    int p, prec, sh;
    sg = !cmd[1] && op[63];
    m  = sg ? (64'd0 - op) : op;
    if (m == 0) return 65'd0;
    prec = cmd[0] ? 24 : 53;
    p = 0;
    for (int i = 0; i < 64; i++) if (m[i]) p = i;
    ix = 1'b0;
    if (p + 1 > prec) begin
      sh   = p + 1 - prec;
      keep = m >> sh;
      rem  = m & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      ix   = (rem != 0);
      if (rem > half || (rem == half && keep[0])) keep = keep + 1;
      if ((keep >> prec) != 0) begin keep = keep >> 1; p = p + 1; end
    end else begin
      keep = m << (prec - 1 - p);
    end
    fr = (keep & ((64'd1 << (prec - 1)) - 1)) << (53 - prec);
    return {ix, sg, 11'(p + 1023), fr[51:0]};
  endfunction

  task automatic run_one(input logic [63:0] op, input logic [1:0] cmd,
                         input int stall, input bit hold, input string tag);
    logic [64:0] e;
    logic [63:0] first;
    int lat;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1 ready idle", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_op = op; in_cmd = cmd;
    @(negedge clk);
    lat = 1;
    if (hold) begin in_op = ~op; in_cmd = ~cmd; end else in_valid = 1'b0;
    while (!out_valid && lat < 10) begin @(negedge clk); lat++; end
    in_valid = 1'b0;
    chk(lat == 3, "R11 latency", 64'(lat), 64'd3);
    first = out_res;
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      chk(out_valid === 1'b1 && out_res === first, "R1 held", out_res, first);
    end
    e = ref_conv(op, cmd);
    chk(out_res === e[63:0], tag, out_res, e[63:0]);
    chk(out_inexact === e[64], "R10 inexact", 64'(out_inexact), 64'(e[64]));
    if (cmd == 2'b00)
      chk(out_res === $realtobits(real'($signed(op))), "R5 real", out_res,
          $realtobits(real'($signed(op))));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 consumed", 64'(out_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    // R2 zero for all commands
    for (int c = 0; c < 4; c++) run_one(64'd0, 2'(c), 0, 0, "R2 zero");
    run_one(64'd1, 2'b00, 0, 0, "R7 one");
    run_one(64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 2, 0, "R4 minus one");
    run_one(64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 0, 0, "R8 carry unsigned");
    run_one(64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 0, 0, "R8 carry single");
    run_one(64'h8000_0000_0000_0000, 2'b00, 0, 0, "R9 most negative");
    run_one(64'h8000_0000_0000_0000, 2'b10, 0, 0, "R3 unsigned top");
    run_one(64'h0020_0000_0000_0001, 2'b10, 0, 0, "R5 tie even");
    run_one(64'h0020_0000_0000_0003, 2'b10, 0, 0, "R5 tie odd");
    run_one(64'h0000_0000_0100_0001, 2'b11, 0, 0, "R6 tie even");
    run_one(64'h0000_0000_0100_0003, 2'b01, 0, 0, "R6 tie odd");
    run_one(64'h0000_0000_01FF_FFFF, 2'b01, 0, 0, "R8 single carry");
    run_one(64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 3, 1, "R1 busy input");
    run_one(64'hFFFF_FFFF_FF00_0001, 2'b01, 0, 0, "R4 negative single");
    for (int n = 0; n < 400; n++) begin
      r = {$urandom, $urandom};
      if ($urandom % 2) r = r >> ($urandom % 64);
      run_one(r, 2'($urandom), int'($urandom % 3), bit'($urandom % 5 == 0),
              "R7 random");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule